// File: doc/BRIEF.md
# Multi-word NVM read request engine

This block serves requests for a run of consecutive 16-bit words from a non-volatile memory. A request carries a starting word offset and a word count. Before any memory access, the block checks the whole range against the memory size. It then reads the words one at a time over a start/address/done/data handshake to a memory backend. The backend may take any number of cycles per word.

While a word is outstanding, the engine samples the backend's done flag once every `POLL_WAIT` clock cycles. It gives up after `POLL_TRIES` samples. The first word that does not complete ends the burst. Words already delivered stay valid, and the final status code reports the error. The default interval is 625 cycles, which is 5 µs at 125 MHz, and the default sample limit is 100000.

Each word leaves the block on a valid/ready stream tagged with its position in the burst. The stream uses these back-pressure rules:
- A presented word holds its data and index until `out_ready` is seen high with `out_valid`.
- The next memory read is not launched until the current word has been taken, so a stalled consumer stalls the memory side.
- `out_ready` may toggle freely and has no effect while `out_valid` is low.

Top module: `nvm_burst_reader`

## Requirements
- R1: A request whose offset is at or beyond `WORDS` ends with status code 1 (range error). It issues no `mem_start` and delivers no word.
- R2: A request whose count is zero, or whose count exceeds `WORDS - offset`, ends with status code 1. It issues no `mem_start` and delivers no word.
- R3: Each word read is launched by a one-cycle `mem_start` with `mem_addr = offset + i`. The value of i runs 0, 1, 2 … in order, and only one read is outstanding at a time.
- R4: The delivered word equals bits [31:16] of `mem_result` when done is seen. Bits [15:0] have no effect on the output.
- R5: Samples of `mem_done` occur `POLL_WAIT`, 2·`POLL_WAIT` … `POLL_TRIES`·`POLL_WAIT` cycles after the `mem_start` cycle. A word succeeds when done is high at one of these samples. A backend latency of exactly `POLL_TRIES`·`POLL_WAIT` cycles still succeeds.
- R6: If no sample sees done, the burst stops. Status code 2 (timeout) is reported, no further `mem_start` is issued, and all earlier words have been delivered.
- R7: A burst in which every word completes delivers exactly `count` words and then reports status code 0.
- R8: `req_ready` is high only while idle. `busy` is high from the cycle after acceptance up to and including the one-cycle `sts_valid` pulse.
- R9: On the output stream, `out_valid` with `out_ready` low holds data and index stable. No `mem_start` occurs while a word is waiting.
- R10: `out_index` carries the word's position in the burst, starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken on this edge |
| req_offset | input | AW | First word offset |
| req_count | input | AW | Number of words |
| busy | output | 1 | Request in progress |
| mem_start | output | 1 | One-cycle launch of a word read |
| mem_addr | output | AW | Word address of the read |
| mem_done | input | 1 | Backend completion flag (level) |
| mem_result | input | 32 | Backend result, data in bits [31:16] |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts word |
| out_data | output | 16 | Word value |
| out_index | output | AW | Position of the word within the burst |
| sts_valid | output | 1 | One-cycle final status strobe |
| sts_code | output | 2 | 0 ok, 1 range error, 2 timeout |

## Verification
The hardest case to reach from the ports is a timeout in the middle of a burst. It needs a backend that is slow for exactly one chosen address while the words before it have already gone out. The bench keeps a latency table per address. It sets one entry one cycle beyond `POLL_TRIES`·`POLL_WAIT`, then exactly at that limit, and also sets the first word of a burst past the limit. Around this, the bench sweeps every offset and count of a 16-word memory, including out-of-range values, while the consumer applies back-pressure.

// File: rtl/nvm_rd_pkg.sv
package nvm_rd_pkg;
  typedef enum logic [1:0] {
    RS_OK      = 2'd0,
    RS_RANGE   = 2'd1,
    RS_TIMEOUT = 2'd2
  } rd_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LAUNCH,
    S_POLL,
    S_EMIT,
    S_REPORT
  } rd_state_e;
endpackage

// File: rtl/nvm_range_check.sv
module nvm_range_check #(
  parameter int WORDS = 64,
  parameter int AW    = $clog2(WORDS + 1)
) (
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] count,
  output logic          ok
);
  localparam logic [AW:0] SIZE = (AW+1)'(WORDS);

  logic [AW:0] room;

  always_comb begin
    room = SIZE - {1'b0, offset};
    ok   = ({1'b0, offset} < SIZE) && (count != '0) && ({1'b0, count} <= room);
  end
endmodule

// File: rtl/nvm_poll_timer.sv
module nvm_poll_timer #(
  parameter int WAIT  = 625,
  parameter int TRIES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  output logic tick,
  output logic last
);
  localparam int WW = $clog2(WAIT + 1);
  localparam int TW = $clog2(TRIES + 1);

  logic [WW-1:0] wait_q;
  logic [TW-1:0] try_q;

  assign tick = active && (wait_q == '0);
  assign last = (try_q == TW'(TRIES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= '0;
      try_q  <= '0;
    end else if (restart) begin
      wait_q <= WW'(WAIT - 1);
      try_q  <= '0;
    end else if (active) begin
      if (wait_q == '0) begin
        wait_q <= WW'(WAIT - 1);
        if (!last) try_q <= try_q + 1'b1;
      end else begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  // R5: never more samples than the limit
  a_r5_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (try_q < TW'(TRIES)));
endmodule

// File: rtl/nvm_word_slot.sv
module nvm_word_slot #(
  parameter int DW = 16,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] in_data,
  input  logic [IW-1:0] in_index,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [IW-1:0] out_index
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_index <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_index <= in_index;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: stalled word holds its contents
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_index)));
endmodule

// File: rtl/nvm_burst_reader.sv
module nvm_burst_reader
  import nvm_rd_pkg::*;
#(
  parameter int WORDS      = 64,
  parameter int POLL_WAIT  = 625,
  parameter int POLL_TRIES = 100000,
  parameter int AW         = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_offset,
  input  logic [AW-1:0] req_count,
  output logic          busy,
  output logic          mem_start,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_done,
  input  logic [31:0]   mem_result,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_data,
  output logic [AW-1:0] out_index,
  output logic          sts_valid,
  output logic [1:0]    sts_code
);
  localparam int DW = 16;

  rd_state_e    state_q;
  rd_status_e   code_q;
  logic [AW-1:0] base_q, total_q, idx_q;
  logic          range_ok, tick, last, load;
  logic [DW-1:0] unused_low;

  assign unused_low = mem_result[DW-1:0];

  nvm_range_check #(.WORDS(WORDS), .AW(AW)) u_range (
    .offset (req_offset),
    .count  (req_count),
    .ok     (range_ok)
  );

  nvm_poll_timer #(.WAIT(POLL_WAIT), .TRIES(POLL_TRIES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_q == S_LAUNCH),
    .active  (state_q == S_POLL),
    .tick    (tick),
    .last    (last)
  );

  assign load = (state_q == S_POLL) && tick && mem_done;

  nvm_word_slot #(.DW(DW), .IW(AW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .in_data   (mem_result[31:16]),
    .in_index  (idx_q),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_index (out_index)
  );

  assign req_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign mem_start = (state_q == S_LAUNCH);
  assign mem_addr  = base_q + idx_q;
  assign sts_valid = (state_q == S_REPORT);
  assign sts_code  = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      code_q  <= RS_OK;
      base_q  <= '0;
      total_q <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          base_q  <= req_offset;
          total_q <= req_count;
          idx_q   <= '0;
          if (range_ok) begin
            state_q <= S_LAUNCH;
          end else begin
            code_q  <= RS_RANGE;
            state_q <= S_REPORT;
          end
        end
        S_LAUNCH: state_q <= S_POLL;
        S_POLL: if (tick) begin
          if (mem_done) begin
            state_q <= S_EMIT;
          end else if (last) begin
            code_q  <= RS_TIMEOUT;
            state_q <= S_REPORT;
          end
        end
        S_EMIT: if (out_valid && out_ready) begin
          if (idx_q == total_q - 1'b1) begin
            code_q  <= RS_OK;
            state_q <= S_REPORT;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_LAUNCH;
          end
        end
        S_REPORT: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  // R3: start is a single-cycle pulse
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |=> !mem_start);

  // R9: no launch while a word waits for the consumer
  a_r9_no_start_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |-> !out_valid);

  // R8: busy persists until the status strobe
  a_r8_busy_until_status: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sts_valid) |=> busy);

  // R6: after status nothing more is issued or presented
  a_r6_quiet_after_status: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |=> (!mem_start && !out_valid));

  // R1: out-of-range request goes straight to range status
  a_r1_range_report: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !range_ok) |=> (sts_valid && sts_code == 2'd1));
endmodule

// File: tb/nvm_burst_reader_tb.sv
module nvm_burst_reader_tb;
  localparam int W  = 16;
  localparam int PW = 2;
  localparam int PT = 4;
  localparam int AW = $clog2(W + 1);
  localparam int LIMIT = PW * PT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_offset = '0, req_count = '0;
  logic req_ready, busy, mem_start, mem_done, out_valid, sts_valid;
  logic out_ready = 1'b0;
  logic [AW-1:0] mem_addr, out_index;
  logic [31:0] mem_result;
  logic [15:0] out_data;
  logic [1:0] sts_code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nvm_burst_reader #(.WORDS(W), .POLL_WAIT(PW), .POLL_TRIES(PT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_count(req_count), .busy(busy),
    .mem_start(mem_start), .mem_addr(mem_addr), .mem_done(mem_done),
    .mem_result(mem_result), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_index(out_index), .sts_valid(sts_valid),
    .sts_code(sts_code)
  );

  function automatic logic [15:0] word_of(input int a);
    return 16'((a * 16'h0123) ^ 16'hBEEF);
  endfunction

  // backend model with per-address latency
  int lat_tab [W];
  logic pend;
  logic [4:0] cnt;
  logic [AW-1:0] cur;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; cnt <= '0; cur <= '0;
    end else if (mem_start) begin
      pend <= 1'b1; cnt <= 5'd1; cur <= mem_addr;
    end else if (pend && cnt != 5'd31) begin
      cnt <= cnt + 1'b1;
    end
  end
  assign mem_done   = pend && (int'(cnt) >= lat_tab[cur[3:0]]);
  assign mem_result = {word_of(int'(cur)), ~word_of(int'(cur))};

  // monitor
  bit bp_mode = 1'b0;
  int cyc = 0;
  int got_n = 0, start_n = 0;
  int got_data [32];
  int got_idx [32];
  int start_addr [32];
  bit sts_seen = 1'b0;
  int sts_got = 0;

  always @(negedge clk) begin
    cyc++;
    out_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
    if (rst_n) begin
      if (out_valid && out_ready && got_n < 32) begin
        got_data[got_n] = int'(out_data);
        got_idx[got_n]  = int'(out_index);
        got_n++;
      end
      if (mem_start && start_n < 32) begin
        start_addr[start_n] = int'(mem_addr);
        start_n++;
      end
      if (sts_valid) begin
        sts_seen = 1'b1;
        sts_got  = int'(sts_code);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_req(input int off, input int n, input string tag);
    int exp_code, exp_words, exp_starts;
    bit valid;
    valid = (off < W) && (n != 0) && (n <= W - off);
    exp_code = 0; exp_words = 0; exp_starts = 0;
    if (!valid) begin
      exp_code = 1;
    end else begin
      exp_words = n;
      exp_starts = n;
      for (int i = 0; i < n; i++) begin
        if (lat_tab[off + i] > LIMIT) begin
          exp_code = 2; exp_words = i; exp_starts = i + 1;
          break;
        end
      end
    end
    got_n = 0; start_n = 0; sts_seen = 1'b0;
    @(negedge clk);
    req_offset = AW'(off); req_count = AW'(n); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1 && req_ready == 1'b0, "R8 busy after accept", int'(busy), 1);
    while (!sts_seen) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R8 idle after status", int'(busy), 0);
    if (exp_code == 1)
      chk(sts_got == 1, (off >= W) ? "R1 range code" : "R2 range code", sts_got, 1);
    else if (exp_code == 2)
      chk(sts_got == 2, "R6 timeout code", sts_got, 2);
    else
      chk(sts_got == 0, "R7 ok code", sts_got, 0);
    chk(got_n == exp_words, exp_code == 2 ? "R6 words before stop" : "R7 word count", got_n, exp_words);
    chk(start_n == exp_starts, exp_code == 1 ? "R1 R2 no reads" : "R3 read count", start_n, exp_starts);
    for (int i = 0; i < start_n && i < exp_starts; i++)
      if (start_addr[i] != off + i) chk(1'b0, "R3 read address", start_addr[i], off + i);
    for (int i = 0; i < got_n && i < exp_words; i++) begin
      if (got_data[i] != int'(word_of(off + i)))
        chk(1'b0, "R4 word data", got_data[i], int'(word_of(off + i)));
      if (got_idx[i] != i) chk(1'b0, "R10 word index", got_idx[i], i);
    end
    if (valid && exp_words > 0) begin
      chk(got_data[exp_words-1] == int'(word_of(off + exp_words - 1)), "R4 last word",
          got_data[exp_words-1], int'(word_of(off + exp_words - 1)));
      chk(got_idx[exp_words-1] == exp_words - 1, "R10 last index", got_idx[exp_words-1], exp_words - 1);
    end
    if (tag.len() > 0) $display("case %s done", tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < W; a++) lat_tab[a] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && req_ready == 1, "R8 reset idle", int'(busy), 0);
    chk(out_valid == 0 && sts_valid == 0 && mem_start == 0, "R9 reset quiet", int'(out_valid), 0);

    // R1 R2 R7 sweep over all offsets and counts, with and without back-pressure
    for (int off = 0; off <= W + 1; off++) begin
      for (int n = 0; n <= W + 1; n++) begin
        for (int a = 0; a < W; a++) lat_tab[a] = 1 + ((a * 3 + off + n) % LIMIT);
        bp_mode = ((off + n) % 2) == 1;
        run_req(off, n, "");
      end
    end

    // R6 mid-burst timeout: one cycle past the sample window
    bp_mode = 1'b1;
    for (int a = 0; a < W; a++) lat_tab[a] = 2;
    lat_tab[5] = LIMIT + 1;
    run_req(3, 6, "r6_mid");
    // R5 boundary: latency equal to the last sample still succeeds
    lat_tab[5] = LIMIT;
    run_req(3, 6, "r5_edge");
    // R6 first word fails
    lat_tab[0] = 20;
    run_req(0, 4, "r6_first");
    // R6 last word of memory fails
    lat_tab[0] = 2; lat_tab[W-1] = LIMIT + 1;
    run_req(W - 3, 3, "r6_last");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule